// File: doc/BRIEF.md
# Conditional Poll Wait Engine

This block executes one wait-until-condition command at a time. A command names a 32-bit location, which is either a register or a memory word depending on a mode bit. The engine reads that location over a simple request/acknowledge read port. It ANDs each returned word with a mask and compares the result against a reference using one of seven functions. When the condition holds, the command ends with pass. While it does not hold, the engine waits a programmed number of idle cycles, reads again, and ends with timeout once its retry budget is used up.

In register mode the command can also bracket the wait with writes on a request/acknowledge write port. A supplied data word is written to the polled register before the first read. After a passing compare, the reference is written to the same register. Malformed commands end at once with an error flag and cause no bus traffic. Every command ends with a one-cycle `done` pulse. The result flags stay valid until the next command is accepted.

Top module: `poll_wait_unit`

## Requirements
- R1: The function code selects how the masked read value (rd_data AND cmd_mask, left operand) is compared with cmd_ref, both taken as unsigned: 3'b001 less than, 3'b010 less or equal, 3'b011 equal, 3'b100 not equal, 3'b101 greater or equal, 3'b110 greater.
- R2: Function code 3'b000 passes on the first read, whatever the data.
- R3: Every read request drives rd_mem equal to the command's mode bit (0 register, 1 memory) and drives rd_addr equal to cmd_addr.
- R4: After a failing compare with retries left, rd_req stays low for exactly cmd_interval cycles before the next read is requested. With an interval of 0, rd_req stays high and the next read follows with no gap.
- R5: With a retry value N other than 12'hFFF, at most N+1 reads are issued. If none passes, the command ends with timeout after read N+1.
- R6: A retry value of 12'hFFF never times out: reads continue until one passes.
- R7: With cmd_op = 2'b01 in register mode, cmd_pre_data is written to cmd_addr before the first read. After a pass, cmd_ref is written to cmd_addr before done. A timeout produces no trailing write. With cmd_op = 2'b00 no writes occur.
- R8: Function code 3'b111, cmd_op values 2'b10 and 2'b11, and cmd_op = 2'b01 with cmd_mem = 1 each end the command with error set, issuing no read and no write.
- R9: After reset, done, pass, timeout, error, rd_req and wr_req are low. done is a one-cycle pulse, during which exactly one of pass, timeout or error is high. That flag stays high until the next accepted command.
- R10: cmd_start while a command is in progress is ignored, and changes to the command inputs during that time have no effect.
- R11: A pending read or write request stays asserted with stable address and data until it is acknowledged, and reads and writes are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Accepts the command inputs when the engine is idle |
| cmd_mem | input | 1 | Polled space: 0 register, 1 memory |
| cmd_op | input | 2 | 00 plain wait, 01 write-wait-write, others illegal |
| cmd_func | input | 3 | Compare function code |
| cmd_addr | input | AW (32) | Polled location address |
| cmd_mask | input | DW (32) | Mask ANDed with each read value |
| cmd_ref | input | DW (32) | Reference value; also the trailing write data |
| cmd_pre_data | input | DW (32) | Data of the leading write |
| cmd_retry | input | RW (12) | Retry budget; all ones means unlimited |
| cmd_interval | input | IW (16) | Idle cycles between reads |
| rd_req | output | 1 | Read request |
| rd_mem | output | 1 | Read space select |
| rd_addr | output | AW (32) | Read address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | DW (32) | Read response data |
| wr_req | output | 1 | Register write request |
| wr_addr | output | AW (32) | Write address |
| wr_data | output | DW (32) | Write data |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle end-of-command pulse |
| pass | output | 1 | Condition met |
| timeout | output | 1 | Retry budget exhausted |
| error | output | 1 | Command rejected as malformed |

## Verification
The bench sweeps all seven functions against values below, equal to and above the reference, including a word with the top bit set. A signed compare or a swapped operand order would then flip pass into timeout on some of these runs. It places the first passing read exactly one read beyond the retry budget and exactly at its end, which catches an off-by-one that gives N or N+2 reads. It counts idle request cycles to catch an interval that is one short or long, or that is skipped when the interval is zero. It also records write traffic in the bracketed variant: a trailing write after a timeout, a missing leading write, or writes swapped in data would all show there. Malformed commands, masked-out bits and starts issued mid-command round out the sweep.

// File: rtl/poll_wait_pkg.sv
// Package: shared encodings for the poll wait engine.
// Assumes: function codes and op codes are fixed by the command format.
package poll_wait_pkg;
    localparam logic [2:0] FN_ALWAYS = 3'd0;
    localparam logic [2:0] FN_LT     = 3'd1;
    localparam logic [2:0] FN_LE     = 3'd2;
    localparam logic [2:0] FN_EQ     = 3'd3;
    localparam logic [2:0] FN_NE     = 3'd4;
    localparam logic [2:0] FN_GE     = 3'd5;
    localparam logic [2:0] FN_GT     = 3'd6;
    localparam logic [2:0] FN_BAD    = 3'd7;

    localparam logic [1:0] OP_PLAIN   = 2'b00;
    localparam logic [1:0] OP_BRACKET = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREWR,
        ST_READ,
        ST_WAIT,
        ST_POSTWR,
        ST_FIN
    } pw_state_e;
endpackage

// File: rtl/pw_compare.sv
// Module: masked unsigned comparator.
// Does: ANDs the read word with the mask and tests it against the reference
//       under the selected function; the read side is the left operand.
// Assumes: illegal code 3'b111 is filtered out before a command starts.
module pw_compare #(
    parameter int DW = 32
) (
    input  logic [2:0]    func,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] ref_val,
    output logic          match
);
    import poll_wait_pkg::*;

    logic [DW-1:0] masked;

    // Select the comparison result for the current function code.
    always_comb begin
        masked = rd_data & mask;
        unique case (func)
            FN_ALWAYS: match = 1'b1;
            FN_LT:     match = (masked <  ref_val);
            FN_LE:     match = (masked <= ref_val);
            FN_EQ:     match = (masked == ref_val);
            FN_NE:     match = (masked != ref_val);
            FN_GE:     match = (masked >= ref_val);
            FN_GT:     match = (masked >  ref_val);
            default:   match = 1'b0;
        endcase
    end
endmodule

// File: rtl/pw_interval_timer.sv
// Module: down-counter for the idle gap between polls.
// Does: loads the interval, counts down one per tick, flags the final cycle.
// Assumes: the controller never loads zero and never ticks an empty counter.
module pw_interval_timer #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] load_val,
    input  logic          tick,
    output logic          last
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] cnt;

    // Load on entry to the gap, decrement once per idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick)
            cnt <= cnt - ONE;
    end

    assign last = (cnt == ONE);

    AST_TICK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt != '0)); // R4
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R4
endmodule

// File: rtl/pw_retry_counter.sv
// Module: retry budget tracker.
// Does: holds remaining retries, knows whether the budget is unlimited,
//       and reports exhaustion once the count reaches zero.
// Assumes: dec is only raised after a failed compare with budget left.
module pw_retry_counter #(
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [RW-1:0] load_val,
    input  logic          dec,
    output logic          exhausted
);
    localparam logic [RW-1:0] FOREVER_CODE = '1;
    localparam logic [RW-1:0] ONE          = RW'(1);

    logic [RW-1:0] cnt;
    logic          forever_q;

    // Capture the budget at command start and count down failed polls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            forever_q <= 1'b0;
        end else if (load) begin
            cnt       <= load_val;
            forever_q <= (load_val == FOREVER_CODE);
        end else if (dec && !forever_q) begin
            cnt <= cnt - ONE;
        end
    end

    assign exhausted = !forever_q && (cnt == '0);

    AST_RETRY_DEC_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !exhausted); // R5
    AST_NO_LOAD_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec)); // R5
endmodule

// File: rtl/pw_fsm.sv
// Module: command sequencer of the poll wait engine.
// Does: accepts and validates a command, issues the optional leading write,
//       polls, spaces retries, issues the optional trailing write and
//       reports one result with a done pulse.
// Assumes: bus responders acknowledge each request exactly once.
module pw_fsm #(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          cmd_mem,
    input  logic [1:0]    cmd_op,
    input  logic [2:0]    cmd_func,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_mask,
    input  logic [DW-1:0] cmd_ref,
    input  logic [DW-1:0] cmd_pre_data,
    input  logic [IW-1:0] cmd_interval,
    input  logic          rd_ack,
    input  logic          wr_ack,
    input  logic          match,
    input  logic          exhausted,
    input  logic          timer_last,
    output logic [2:0]    func_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] ref_q,
    output logic          retry_load,
    output logic          retry_dec,
    output logic          timer_load,
    output logic          timer_tick,
    output logic [IW-1:0] interval_q,
    output logic          rd_req,
    output logic          rd_mem,
    output logic [AW-1:0] rd_addr,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic          pass,
    output logic          timeout,
    output logic          error
);
    import poll_wait_pkg::*;

    pw_state_e     state;
    logic          mem_q;
    logic [1:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] pre_q;
    logic          pass_q;
    logic          timeout_q;
    logic          error_q;
    logic          cmd_bad;
    logic          accept;
    logic          poll_fail;

    // Decide whether an incoming command is malformed.
    always_comb begin
        cmd_bad = (cmd_func == FN_BAD) || cmd_op[1]
                  || ((cmd_op == OP_BRACKET) && cmd_mem);
    end

    assign accept    = (state == ST_IDLE) && cmd_start;
    assign poll_fail = (state == ST_READ) && rd_ack && !match;

    // Strobes for the retry counter and the interval timer.
    always_comb begin
        retry_load = accept;
        retry_dec  = poll_fail && !exhausted;
        timer_load = retry_dec && (interval_q != '0);
        timer_tick = (state == ST_WAIT);
    end

    // Latch the command fields when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q      <= 1'b0;
            op_q       <= OP_PLAIN;
            func_q     <= FN_ALWAYS;
            addr_q     <= '0;
            mask_q     <= '0;
            ref_q      <= '0;
            pre_q      <= '0;
            interval_q <= '0;
        end else if (accept) begin
            mem_q      <= cmd_mem;
            op_q       <= cmd_op;
            func_q     <= cmd_func;
            addr_q     <= cmd_addr;
            mask_q     <= cmd_mask;
            ref_q      <= cmd_ref;
            pre_q      <= cmd_pre_data;
            interval_q <= cmd_interval;
        end
    end

    // Main sequencing and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pass_q    <= 1'b0;
            timeout_q <= 1'b0;
            error_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        pass_q    <= 1'b0;
                        timeout_q <= 1'b0;
                        error_q   <= cmd_bad;
                        if (cmd_bad)
                            state <= ST_FIN;
                        else if (cmd_op == OP_BRACKET)
                            state <= ST_PREWR;
                        else
                            state <= ST_READ;
                    end
                end
                ST_PREWR: begin
                    if (wr_ack)
                        state <= ST_READ;
                end
                ST_READ: begin
                    if (rd_ack) begin
                        if (match) begin
                            if (op_q == OP_BRACKET) begin
                                state <= ST_POSTWR;
                            end else begin
                                pass_q <= 1'b1;
                                state  <= ST_FIN;
                            end
                        end else if (exhausted) begin
                            timeout_q <= 1'b1;
                            state     <= ST_FIN;
                        end else if (interval_q != '0) begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (timer_last)
                        state <= ST_READ;
                end
                ST_POSTWR: begin
                    if (wr_ack) begin
                        pass_q <= 1'b1;
                        state  <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus and result outputs decoded from the registered state.
    always_comb begin
        rd_req  = (state == ST_READ);
        rd_mem  = mem_q;
        rd_addr = addr_q;
        wr_req  = (state == ST_PREWR) || (state == ST_POSTWR);
        wr_addr = addr_q;
        wr_data = (state == ST_PREWR) ? pre_q : ref_q;
        done    = (state == ST_FIN);
        pass    = pass_q;
        timeout = timeout_q;
        error   = error_q;
    end

    AST_DONE_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({pass_q, timeout_q, error_q})); // R9
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R11
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_mem))); // R11
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data) && $stable(wr_addr))); // R11
    AST_WR_REG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !mem_q); // R7
    AST_ERROR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        error_q |-> (!rd_req && !wr_req)); // R8
    AST_TIMEOUT_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_q) |-> $past(exhausted)); // R5
endmodule

// File: rtl/poll_wait_unit.sv
// Module: top of the poll wait engine.
// Does: connects the sequencer, comparator, retry counter and interval timer.
// Assumes: one command at a time; the command inputs need only be valid
//          in the cycle cmd_start is sampled.
module poll_wait_unit #(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int RW = 12,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          cmd_mem,
    input  logic [1:0]    cmd_op,
    input  logic [2:0]    cmd_func,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_mask,
    input  logic [DW-1:0] cmd_ref,
    input  logic [DW-1:0] cmd_pre_data,
    input  logic [RW-1:0] cmd_retry,
    input  logic [IW-1:0] cmd_interval,
    output logic          rd_req,
    output logic          rd_mem,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ack,
    output logic          done,
    output logic          pass,
    output logic          timeout,
    output logic          error
);
    logic [2:0]    func_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] ref_q;
    logic          match;
    logic          exhausted;
    logic          retry_load;
    logic          retry_dec;
    logic          timer_load;
    logic          timer_tick;
    logic          timer_last;
    logic [IW-1:0] interval_q;

    pw_fsm #(.DW(DW), .AW(AW), .IW(IW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .cmd_mem      (cmd_mem),
        .cmd_op       (cmd_op),
        .cmd_func     (cmd_func),
        .cmd_addr     (cmd_addr),
        .cmd_mask     (cmd_mask),
        .cmd_ref      (cmd_ref),
        .cmd_pre_data (cmd_pre_data),
        .cmd_interval (cmd_interval),
        .rd_ack       (rd_ack),
        .wr_ack       (wr_ack),
        .match        (match),
        .exhausted    (exhausted),
        .timer_last   (timer_last),
        .func_q       (func_q),
        .mask_q       (mask_q),
        .ref_q        (ref_q),
        .retry_load   (retry_load),
        .retry_dec    (retry_dec),
        .timer_load   (timer_load),
        .timer_tick   (timer_tick),
        .interval_q   (interval_q),
        .rd_req       (rd_req),
        .rd_mem       (rd_mem),
        .rd_addr      (rd_addr),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .done         (done),
        .pass         (pass),
        .timeout      (timeout),
        .error        (error)
    );

    pw_compare #(.DW(DW)) u_cmp (
        .func    (func_q),
        .rd_data (rd_data),
        .mask    (mask_q),
        .ref_val (ref_q),
        .match   (match)
    );

    pw_retry_counter #(.RW(RW)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (retry_load),
        .load_val  (cmd_retry),
        .dec       (retry_dec),
        .exhausted (exhausted)
    );

    pw_interval_timer #(.IW(IW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (interval_q),
        .tick     (timer_tick),
        .last     (timer_last)
    );
endmodule

// File: tb/poll_wait_unit_test.sv
module poll_wait_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_mem = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [2:0]  cmd_func = 3'd0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_mask = '0;
    logic [31:0] cmd_ref = '0;
    logic [31:0] cmd_pre_data = '0;
    logic [11:0] cmd_retry = '0;
    logic [15:0] cmd_interval = '0;
    logic        rd_req, rd_mem, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        wr_ack = 1'b0;
    logic        done, pass, timeout, error;

    int checks = 0;
    int errors = 0;

    logic [31:0] script [32];
    int          rd_idx = 0;
    int          wr_cnt = 0;
    int          gap = 0;
    int          bus_bad = 0;
    logic [31:0] exp_addr = '0;
    logic        exp_mem = 1'b0;
    logic [31:0] wr_log_d [4];
    logic [31:0] wr_log_a [4];

    always #4 clk = ~clk;

    poll_wait_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mem(cmd_mem),
        .cmd_op(cmd_op), .cmd_func(cmd_func), .cmd_addr(cmd_addr),
        .cmd_mask(cmd_mask), .cmd_ref(cmd_ref), .cmd_pre_data(cmd_pre_data),
        .cmd_retry(cmd_retry), .cmd_interval(cmd_interval),
        .rd_req(rd_req), .rd_mem(rd_mem), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack), .done(done), .pass(pass), .timeout(timeout), .error(error)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit cmpf(input logic [2:0] f, input logic [31:0] a,
                                input logic [31:0] b);
        case (f)
            3'd0: return 1'b1;
            3'd1: return a < b;
            3'd2: return a <= b;
            3'd3: return a == b;
            3'd4: return a != b;
            3'd5: return a >= b;
            3'd6: return a > b;
            default: return 1'b0;
        endcase
    endfunction

    // Bus responders and gap monitor, all acting at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_idx > 0 && !rd_req && !wr_req && !done)
                gap++;
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (rd_mem !== exp_mem || rd_addr !== exp_addr)
                    bus_bad++;
                rd_data = script[(rd_idx < 32) ? rd_idx : 31];
                rd_ack  = 1'b1;
                rd_idx++;
            end
            if (wr_ack) begin
                wr_ack = 1'b0;
            end else if (wr_req) begin
                if (wr_cnt < 4) begin
                    wr_log_d[wr_cnt] = wr_data;
                    wr_log_a[wr_cnt] = wr_addr;
                end
                wr_ack = 1'b1;
                wr_cnt++;
            end
        end
    end

    // Run one command and compare every observable result with the model.
    task automatic run(input string tag, input logic [2:0] f, input logic mem,
                       input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] mask, input logic [31:0] refv,
                       input logic [31:0] pre, input logic [11:0] retry,
                       input logic [15:0] intv, input bit poke);
        bit bad, exp_pass, exp_to, got, poked;
        int lim, exp_reads, exp_writes;
        bad = (f == 3'd7) || op[1] || (op == 2'b01 && mem);
        lim = (retry == 12'hFFF) ? 32 : int'(retry) + 1;
        exp_pass = 1'b0;
        exp_reads = lim;
        for (int k = 0; k < lim; k++) begin
            if (!exp_pass && cmpf(f, script[k] & mask, refv)) begin
                exp_pass = 1'b1;
                exp_reads = k + 1;
            end
        end
        exp_to = !exp_pass;
        if (bad) begin
            exp_pass = 1'b0; exp_to = 1'b0; exp_reads = 0;
        end
        exp_writes = (!bad && op == 2'b01) ? (exp_pass ? 2 : 1) : 0;

        @(negedge clk);
        rd_idx = 0; wr_cnt = 0; gap = 0; bus_bad = 0;
        exp_addr = addr; exp_mem = mem;
        cmd_func = f; cmd_mem = mem; cmd_op = op; cmd_addr = addr;
        cmd_mask = mask; cmd_ref = refv; cmd_pre_data = pre;
        cmd_retry = retry; cmd_interval = intv; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        got = 1'b0; poked = 1'b0;
        for (int c = 0; c < 20000 && !got; c++) begin
            if (done) begin
                got = 1'b1;
            end else begin
                if (poke && !poked && rd_idx >= 1) begin
                    // R10: new start and altered fields while busy
                    cmd_func = 3'd0; cmd_mask = '0; cmd_interval = 16'd0;
                    cmd_addr = ~addr; cmd_start = 1'b1;
                    poked = 1'b1;
                end else begin
                    cmd_start = 1'b0;
                end
                @(negedge clk);
            end
        end
        cmd_start = 1'b0;
        chk(tag, "done seen", {31'd0, got}, 32'd1);
        if (!got) return;
        chk(tag, "pass", {31'd0, pass}, {31'd0, exp_pass});
        chk(tag, "timeout", {31'd0, timeout}, {31'd0, exp_to});
        chk("R8", "error", {31'd0, error}, {31'd0, bad});
        chk("R5", "read count", rd_idx, exp_reads);
        chk("R4", "idle gap cycles", gap,
            (exp_reads > 0) ? int'(intv) * (exp_reads - 1) : 0);
        chk("R3", "read space/address mismatches", bus_bad, 0);
        chk("R7", "write count", wr_cnt, exp_writes);
        if (exp_writes >= 1) begin
            chk("R7", "leading write data", wr_log_d[0], pre);
            chk("R7", "leading write addr", wr_log_a[0], addr);
        end
        if (exp_writes == 2) begin
            chk("R7", "trailing write data", wr_log_d[1], refv);
            chk("R7", "trailing write addr", wr_log_a[1], addr);
        end
        @(negedge clk);
        chk("R9", "done pulse width", {31'd0, done}, 32'd0);
        chk("R9", "flags held", {29'd0, pass, timeout, error},
            {29'd0, exp_pass, exp_to, bad});
    endtask

    task automatic fill_const(input logic [31:0] v);
        for (int k = 0; k < 32; k++) script[k] = v;
    endtask

    task automatic fill_ramp();
        for (int k = 0; k < 32; k++) script[k] = k;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] vals [4];
        vals[0] = 32'h0000_00FF; vals[1] = 32'h0000_0100;
        vals[2] = 32'h0000_0101; vals[3] = 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset outputs", {26'd0, done, pass, timeout, error, rd_req, wr_req},
            32'd0);

        // R1 / R2: all functions against below, equal, above, top-bit-set values
        for (int f = 0; f < 7; f++) begin
            for (int v = 0; v < 4; v++) begin
                fill_const(vals[v]);
                run((f == 0) ? "R2" : "R1", 3'(f), 1'(f % 2), 2'b00,
                    32'h0000_1000 + 32'(f), 32'hFFFF_FFFF, 32'h0000_0100,
                    32'd0, 12'd2, 16'(v % 3), 1'b0);
            end
        end

        // R1: mask removes upper bits before compare
        fill_const(32'hABCD_0005);
        run("R1", 3'd3, 1'b1, 2'b00, 32'h40, 32'h0000_00FF, 32'h5, 0, 12'd1, 16'd1, 1'b0);
        run("R1", 3'd3, 1'b1, 2'b00, 32'h40, 32'hFFFF_FFFF, 32'h5, 0, 12'd1, 16'd1, 1'b0);

        // R4 / R5: ramp reaches the reference after several retries
        fill_ramp();
        run("R4", 3'd3, 1'b0, 2'b00, 32'h80, '1, 32'd5, 0, 12'd7, 16'd2, 1'b0);
        run("R5", 3'd3, 1'b0, 2'b00, 32'h84, '1, 32'd4, 0, 12'd4, 16'd1, 1'b0);
        run("R5", 3'd3, 1'b0, 2'b00, 32'h88, '1, 32'd4, 0, 12'd3, 16'd1, 1'b0);
        run("R5", 3'd3, 1'b0, 2'b00, 32'h8C, '1, 32'd9, 0, 12'd0, 16'd3, 1'b0);
        run("R4", 3'd5, 1'b1, 2'b00, 32'h90, '1, 32'd3, 0, 12'd5, 16'd0, 1'b0);

        // R6: unlimited retries
        run("R6", 3'd3, 1'b1, 2'b00, 32'h94, '1, 32'd25, 0, 12'hFFF, 16'd0, 1'b0);
        run("R6", 3'd6, 1'b0, 2'b00, 32'h98, '1, 32'd12, 0, 12'hFFF, 16'd1, 1'b0);

        // R7: bracketed variant, pass and timeout
        run("R7", 3'd5, 1'b0, 2'b01, 32'hA0, '1, 32'd3, 32'hDEAD_0001, 12'd6, 16'd1, 1'b0);
        run("R7", 3'd3, 1'b0, 2'b01, 32'hA4, '1, 32'd30, 32'hBEEF_0002, 12'd2, 16'd1, 1'b0);

        // R8: malformed commands
        run("R8", 3'd7, 1'b0, 2'b00, 32'hB0, '1, 32'd0, 0, 12'd2, 16'd1, 1'b0);
        run("R8", 3'd3, 1'b0, 2'b10, 32'hB4, '1, 32'd0, 0, 12'd2, 16'd1, 1'b0);
        run("R8", 3'd3, 1'b0, 2'b11, 32'hB8, '1, 32'd0, 0, 12'd2, 16'd1, 1'b0);
        run("R8", 3'd3, 1'b1, 2'b01, 32'hBC, '1, 32'd0, 0, 12'd2, 16'd1, 1'b0);

        // R10: start pulse and changed fields while busy are ignored
        fill_const(32'h0000_0007);
        run("R10", 3'd3, 1'b0, 2'b00, 32'hC0, '1, 32'd8, 0, 12'd3, 16'd2, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule